// File: doc/BRIEF.md
# Scrolled Tile Background Pixel Fetch

This block finds the palette colour index of the background layer for one screen pixel at a time in a tile-based video generator. The screen position and a scroll offset give a position on a larger background canvas that wraps at its edges. That canvas is made of 16x16-pixel tiles laid out 40 tiles across and 30 tiles down. The block looks up the tile's attribute word in an external attribute memory. The attribute word holds two mirror flags, a palette selector and the index of the tile's pixel data.

The block then reads the tile pixel memory. That memory packs five 3-bit pixels into each 15-bit word, and each tile occupies 52 words. The block picks the right 3-bit slot from the returned word and joins it with the palette selector to form the colour index.

Both memories are synchronous, with one cycle of read latency. Their address ports are driven straight from logic, in the cycle in which the memory samples them. The pipeline accepts a new pixel every clock. The colour index appears three clock edges after the pixel coordinates are presented.

Top module: `bg_tile_fetch`

## Requirements
- R1: The canvas position is ((scr_x + scroll_x) mod 640, (scr_y + scroll_y) mod 480), so a scroll past one edge reads the opposite side.
- R2: In the cycle the coordinates are presented, attr_addr equals tile_row*40 + tile_col, where tile_col = canvas_x/16 and tile_row = canvas_y/16. It is therefore always below 1200.
- R3: The attribute word is decoded as follows. Bit 14 set mirrors the local row (local_y becomes 15 - local_y). Bit 13 set mirrors the local column (local_x becomes 15 - local_x). Bits 12..10 are the palette selector, and bits 9..0 are the tile data index. The local coordinates are canvas_x mod 16 and canvas_y mod 16.
- R4: One cycle after the coordinates, while attr_data holds the attribute word, tile_addr equals index*52 + p/5. Here p = local_y*16 + local_x, taken after mirroring.
- R5: The pixel value is bits 3s+2..3s of the returned tile word, where s = p mod 5.
- R6: Three clock edges after the coordinates are presented, cidx equals palette*8 + pixel value. For example, screen (25,60) with scroll (3,3), attribute word 0x4814 at address 121 and tile word 0x7e3f at address 1042 give cidx 16.
- R7: A clock edge at which oe is low leaves cidx at zero.
- R8: A clock edge with rst high clears cidx to zero, together with the pipeline's stage registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| oe | input | 1 | Output enable for cidx |
| scr_x | input | 10 | Screen pixel column |
| scr_y | input | 9 | Screen pixel row |
| scroll_x | input | 10 | Horizontal scroll offset |
| scroll_y | input | 9 | Vertical scroll offset |
| attr_addr | output | 11 | Attribute memory address |
| attr_data | input | 15 | Attribute memory read data (one cycle latency) |
| tile_addr | output | 16 | Tile pixel memory address |
| tile_data | input | 15 | Tile pixel memory read data (one cycle latency) |
| cidx | output | 6 | Palette colour index |

## Verification
A stale local-coordinate register, or a palette or slot register that is out of step with the memory data, shows up as a wrong tile_addr one cycle later or a wrong cidx three edges later. It shows up on the very pixel it corrupts. A stream that changes pixel on every clock therefore exposes any pipeline misalignment at once. Bad wrap arithmetic or a bad tile split shows on attr_addr in the same cycle. A wrong mirror or slot decode changes tile_addr or the low three bits of cidx, so the sweeps cover every local position under all four flag combinations.

// File: rtl/bg_tile_fetch.sv
module bg_tile_fetch #(
  parameter int XW = 10,
  parameter int YW = 9,
  parameter int TILES_X = 40,
  parameter int TILES_Y = 30,
  parameter int WORDS_PER_TILE = 52,
  parameter int AADDR_W = 11,
  parameter int TADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               oe,
  input  logic [XW-1:0]      scr_x,
  input  logic [YW-1:0]      scr_y,
  input  logic [XW-1:0]      scroll_x,
  input  logic [YW-1:0]      scroll_y,
  output logic [AADDR_W-1:0] attr_addr,
  input  logic [14:0]        attr_data,
  output logic [TADDR_W-1:0] tile_addr,
  input  logic [14:0]        tile_data,
  output logic [5:0]         cidx
);
  localparam int TS = 16;
  localparam int SLOTS = 5;
  localparam int CANVAS_W = TILES_X * TS;
  localparam int CANVAS_H = TILES_Y * TS;
  localparam int B_MIRROR_Y = 14;
  localparam int B_MIRROR_X = 13;

  logic [31:0] cx, cy;
  logic [3:0]  lx_r, ly_r, fx, fy;
  logic [7:0]  pix;
  logic [2:0]  pal_r, slot_r;

  assign cx = (32'(scr_x) + 32'(scroll_x)) % CANVAS_W;
  assign cy = (32'(scr_y) + 32'(scroll_y)) % CANVAS_H;
  assign attr_addr = AADDR_W'((cy / TS) * TILES_X + cx / TS);

  assign fx  = attr_data[B_MIRROR_X] ? ~lx_r : lx_r;
  assign fy  = attr_data[B_MIRROR_Y] ? ~ly_r : ly_r;
  assign pix = {fy, fx};
  assign tile_addr = TADDR_W'(32'(attr_data[9:0]) * WORDS_PER_TILE + 32'(pix) / SLOTS);

  always_ff @(posedge clk) begin
    if (rst) begin
      lx_r   <= '0;
      ly_r   <= '0;
      pal_r  <= '0;
      slot_r <= '0;
      cidx   <= '0;
    end else begin
      lx_r   <= 4'(cx % TS);
      ly_r   <= 4'(cy % TS);
      pal_r  <= attr_data[12:10];
      slot_r <= 3'(32'(pix) % SLOTS);
      cidx   <= oe ? {pal_r, tile_data[3*slot_r +: 3]} : 6'd0;
    end
  end
endmodule

module bg_tile_fetch_chk #(
  parameter int TILES_X = 40,
  parameter int TILES_Y = 30,
  parameter int WORDS_PER_TILE = 52,
  parameter int AADDR_W = 11,
  parameter int TADDR_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               oe,
  input logic [AADDR_W-1:0] attr_addr,
  input logic [14:0]        attr_data,
  input logic [TADDR_W-1:0] tile_addr,
  input logic [5:0]         cidx
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assert_oe_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !oe |=> cidx == 6'd0);

  assert_attr_range_R2: assert property (@(posedge clk) disable iff (rst)
    32'(attr_addr) < TILES_X * TILES_Y);

  assert_tile_base_R4: assert property (@(posedge clk) disable iff (rst)
    32'(tile_addr) / WORDS_PER_TILE == 32'(attr_data[9:0]));

  assert_palette_R6: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(oe)) |-> cidx[5:3] == $past(attr_data[12:10], 2));
endmodule

bind bg_tile_fetch bg_tile_fetch_chk #(
  .TILES_X(TILES_X), .TILES_Y(TILES_Y), .WORDS_PER_TILE(WORDS_PER_TILE),
  .AADDR_W(AADDR_W), .TADDR_W(TADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .oe(oe), .attr_addr(attr_addr),
  .attr_data(attr_data), .tile_addr(tile_addr), .cidx(cidx)
);

// File: tb/bg_tile_fetch_tb.sv
module bg_tile_fetch_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oe = 1'b0;
  logic [9:0]  scr_x = '0, scroll_x = '0;
  logic [8:0]  scr_y = '0, scroll_y = '0;
  logic [10:0] attr_addr;
  logic [14:0] attr_data = '0;
  logic [15:0] tile_addr;
  logic [14:0] tile_data = '0;
  logic [5:0]  cidx;

  int errors = 0;
  int checks = 0;
  int n = 0;
  int h_taddr [4];
  int h_cidx [4];
  bit h_oe [4];

  always #10 clk = ~clk;

  bg_tile_fetch u_dut (
    .clk(clk), .rst(rst), .oe(oe), .scr_x(scr_x), .scr_y(scr_y),
    .scroll_x(scroll_x), .scroll_y(scroll_y), .attr_addr(attr_addr),
    .attr_data(attr_data), .tile_addr(tile_addr), .tile_data(tile_data),
    .cidx(cidx));

  function automatic logic [14:0] attr_f(int a);
    if (a == 121) return 15'h4814;
    return 15'((a * 7919) ^ (a << 9) ^ (a >> 2));
  endfunction

  function automatic logic [14:0] tile_f(int t);
    if (t == 1042) return 15'h7e3f;
    return 15'((t * 40503) ^ (t >> 4));
  endfunction

  always_ff @(posedge clk) begin
    attr_data <= attr_f(int'(attr_addr));
    tile_data <= tile_f(int'(tile_addr));
  end

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic model(int x, int y, int sx, int sy, output int aa, output int ta, output int c);
    int cx, cy, lx, ly, p, w;
    logic [14:0] at;
    cx = (x + sx) % 640;
    cy = (y + sy) % 480;
    aa = (cy / 16) * 40 + cx / 16;
    at = attr_f(aa);
    lx = cx % 16;
    ly = cy % 16;
    if (at[13]) lx = 15 - lx;
    if (at[14]) ly = 15 - ly;
    p = ly * 16 + lx;
    ta = int'(at[9:0]) * 52 + p / 5;
    w = int'(tile_f(ta));
    c = int'(at[12:10]) * 8 + ((w >> (3 * (p % 5))) & 7);
  endtask

  task automatic step(int x, int y, int sx, int sy, bit en);
    int aa, ta, c, exp;
    @(negedge clk);
    if (n >= 1)
      check(int'(tile_addr) == h_taddr[(n-1)%4], "R3/R4 tile_addr", int'(tile_addr), h_taddr[(n-1)%4]);
    if (n >= 3) begin
      exp = h_oe[(n-1)%4] ? h_cidx[(n-3)%4] : 0;
      if (h_oe[(n-1)%4])
        check(int'(cidx) == exp, "R5/R6 cidx", int'(cidx), exp);
      else
        check(cidx == 6'd0, "R7 cidx with oe low", int'(cidx), 0);
    end
    scr_x = 10'(x); scr_y = 9'(y); scroll_x = 10'(sx); scroll_y = 9'(sy); oe = en;
    model(x, y, sx, sy, aa, ta, c);
    #1;
    check(int'(attr_addr) == aa, "R1/R2 attr_addr", int'(attr_addr), aa);
    h_taddr[n%4] = ta;
    h_cidx[n%4] = c;
    h_oe[n%4] = en;
    n++;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cidx == 6'd0, "R8 cidx in reset", int'(cidx), 0);
    rst = 1'b0;
    n = 0;

    // worked example held for several cycles
    for (int i = 0; i < 5; i++) step(25, 60, 3, 3, 1'b1);
    check(int'(cidx) == 16, "R6 worked example cidx", int'(cidx), 16);
    check(int'(tile_addr) == 1042, "R4 worked example tile_addr", int'(tile_addr), 1042);

    // every local position across many tiles and flag combinations
    for (int y = 0; y < 48; y++)
      for (int x = 0; x < 64; x++) step(x, y, 0, 0, 1'b1);

    // wrap on both axes (R1)
    for (int y = 460; y < 500; y++)
      for (int x = 600; x < 680; x += 3) step(x, y, 30 + x % 7, 15, 1'b1);
    step(1023, 511, 1023, 511, 1'b1);
    step(639, 479, 1, 1, 1'b1);

    // output enable toggling (R7)
    for (int i = 0; i < 300; i++) step((i * 37) % 1024, (i * 13) % 512, i % 50, i % 20, (i % 3) != 0);

    // coarse sweep over the whole screen with scroll
    for (int y = 0; y < 480; y += 11)
      for (int x = 0; x < 640; x += 7) step(x, y, 211, 97, 1'b1);
    step(0, 0, 0, 0, 1'b1);
    step(0, 0, 0, 0, 1'b1);
    step(0, 0, 0, 0, 1'b1);

    // reset during activity (R8)
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(cidx == 6'd0, "R8 cidx after reset edge", int'(cidx), 0);
    @(negedge clk);
    check(cidx == 6'd0, "R8 cidx held in reset", int'(cidx), 0);
    rst = 1'b0;
    n = 0;
    for (int i = 0; i < 20; i++) step(100 + i, 200, 5, 5, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule